// File: doc/BRIEF.md
# Embedded-Parity 256-bit Code Word Former

This block turns an arbitrary 256-bit value into a word that is itself a valid single-error-correcting, double-error-detecting code word. It adds no check bits. Instead, it flips at most two data bits and then adjusts bit 0. Afterwards, two things hold for the word: the XOR of the positions of all its set bits is zero, and it holds an even number of ones. A key-provisioning flow uses it to condition a random secret before the secret is burned into one-time-programmable storage.

A start strobe captures the input value and a flag. When the flag is set, the four top positions (252..255) are forced to one before encoding begins, because those fuses may already be burned. Encoding never touches positions 252..255, so a one placed there is never asked to return to zero. The result appears two clock edges after the strobe and is marked by a one-cycle done pulse. It then holds until the next result.

Top module: `hamcw_encoder`

## Requirements
- R1: While reset is asserted, `code_o` is all zeros and `done_o` is low.
- R2: A start sampled high at clock edge k produces exactly one `done_o` pulse, which is high for the cycle after edge k+1. `done_o` is never high without such a start.
- R3: `code_o` changes only in a cycle where `done_o` is high, and otherwise holds its last value.
- R4: In every result, the XOR of the indices (0..255) of all set bits of `code_o` is zero.
- R5: In every result, `code_o` has an even number of set bits.
- R6: With `minimal_i` high at start, `code_o[255:252]` is 4'b1111.
- R7: With `minimal_i` low at start, `code_o[255:252]` equals `data_i[255:252]`.
- R8: Let w be the prepared word, s the XOR of the indices of its set bits, and p its bit parity. If s < 252, bit s is inverted and p is toggled. Otherwise, bits s-4 and 4 are inverted. Finally, bit 0 is XORed with p. The result is `code_o`.
- R9: An input that already satisfies R4 and R5 passes through unchanged. Examples are all zeros, all ones, and all zeros in minimal mode.
- R10: Starts on consecutive cycles each yield their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture strobe for `data_i` and `minimal_i` |
| minimal_i | input | 1 | Force bits 255:252 to one before encoding |
| data_i | input | 256 | Raw value to encode |
| code_o | output | 256 | Encoded word |
| done_o | output | 1 | One-cycle pulse when `code_o` is new |

## Verification
A corrupted syndrome or parity term inside the block shows up at the ports in the same cycle that `done_o` rises. The emitted word then has a non-zero index XOR or odd weight, or it differs from the word predicted by R8. A stray or lost valid bit in the two-stage pipeline shows up one cycle later at most: a done pulse at the wrong cycle, or an output that moves while `done_o` is low. Vectors aimed at s exactly in the reserved range, at s = 0 and at already-valid words pin down the fix-up choices.

// File: rtl/hamcw_pkg.sv
package hamcw_pkg;
  // Kind of correction chosen for a syndrome
  typedef enum logic [0:0] {
    FIX_SINGLE = 1'b0,   // syndrome points at a free data position
    FIX_PAIR   = 1'b1    // syndrome points into the reserved top field
  } fix_kind_e;
endpackage

// File: rtl/hamcw_rst_sync.sv
module hamcw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hamcw_syndrome.sv
module hamcw_syndrome #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     word_i,
  output logic [IDX_W-1:0] syn_o,
  output logic             par_o
);
  // One XOR tree per index bit: bit b of the syndrome collects every
  // word position whose index has bit b set.
  for (genvar b = 0; b < IDX_W; b++) begin : g_synbit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (((i >> b) & 1) == 1) acc = acc ^ word_i[i];
      end
    end
    assign syn_o[b] = acc;
  end

  assign par_o = ^word_i;
endmodule

// File: rtl/hamcw_fixup.sv
module hamcw_fixup
  import hamcw_pkg::*;
#(
  parameter int unsigned W     = 256,
  parameter int unsigned RSV   = 4,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     word_i,
  input  logic [IDX_W-1:0] syn_i,
  input  logic             par_i,
  output logic [W-1:0]     code_o
);
  localparam logic [IDX_W-1:0] LIMIT   = IDX_W'(W - RSV);
  localparam logic [IDX_W-1:0] RSV_IDX = IDX_W'(RSV);

  fix_kind_e        kind;
  logic             par_adj;
  logic [IDX_W-1:0] alt_idx;

  always_comb begin
    kind    = (syn_i < LIMIT) ? FIX_SINGLE : FIX_PAIR;
    alt_idx = syn_i - RSV_IDX;
    code_o  = word_i;
    par_adj = par_i;
    if (kind == FIX_SINGLE) begin
      code_o[syn_i] = ~code_o[syn_i];
      par_adj       = ~par_adj;
    end else begin
      code_o[alt_idx] = ~code_o[alt_idx];
      code_o[RSV_IDX] = ~code_o[RSV_IDX];
    end
    code_o[0] = code_o[0] ^ par_adj;
  end
endmodule

// File: rtl/hamcw_encoder.sv
module hamcw_encoder #(
  parameter int unsigned W     = 256,
  parameter int unsigned RSV   = 4,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         minimal_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] code_o,
  output logic         done_o
);
  localparam logic [W-1:0] TOP_MASK = {{RSV{1'b1}}, {(W-RSV){1'b0}}};

  logic rst_int_n;

  hamcw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Stage A: capture prepared word
  logic         a_vld_q, a_vld_d;
  logic [W-1:0] a_word_q, a_word_d;
  logic         a_en;

  always_comb begin
    a_vld_d  = start_i;
    a_en     = start_i;
    a_word_d = minimal_i ? (data_i | TOP_MASK) : data_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      a_vld_q  <= 1'b0;
      a_word_q <= '0;
    end else begin
      a_vld_q <= a_vld_d;
      if (a_en) a_word_q <= a_word_d;
    end
  end

  // Syndrome and correction
  logic [IDX_W-1:0] syn;
  logic             par;
  logic [W-1:0]     fixed;

  hamcw_syndrome #(.W(W), .IDX_W(IDX_W)) u_syndrome (
    .word_i (a_word_q),
    .syn_o  (syn),
    .par_o  (par)
  );

  hamcw_fixup #(.W(W), .RSV(RSV), .IDX_W(IDX_W)) u_fixup (
    .word_i (a_word_q),
    .syn_i  (syn),
    .par_i  (par),
    .code_o (fixed)
  );

  // Stage B: output register
  logic         b_en;
  logic         done_d, done_q;
  logic [W-1:0] code_d, code_q;

  always_comb begin
    b_en   = a_vld_q;
    done_d = a_vld_q;
    code_d = fixed;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= done_d;
      if (b_en) code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;

  // Assertions
  logic [IDX_W-1:0] chk_syn;
  always_comb begin
    chk_syn = '0;
    for (int i = 0; i < W; i++) begin
      if (code_q[i]) chk_syn = chk_syn ^ IDX_W'(i);
    end
  end

  AST_DONE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i, 2)); // R2
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o)); // R3
  AST_SYNDROME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_syn == '0)); // R4
  AST_EVEN_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(^code_o)); // R5
  AST_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (code_o[W-1:W-RSV] == $past(a_word_q[W-1:W-RSV]))); // R7
  AST_FEW_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(code_o ^ $past(a_word_q)) <= 3)); // R8
endmodule

// File: tb/hamcw_encoder_bench.sv
module hamcw_encoder_bench;
  localparam int W = 256;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         minimal_i;
  logic [W-1:0] data_i;
  logic [W-1:0] code_o;
  logic         done_o;

  hamcw_encoder u_hamcw_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .minimal_i (minimal_i),
    .data_i    (data_i),
    .code_o    (code_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;
  bit mon_on   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [W-1:0] exp;
    logic [3:0]   top;
    int           due;
  } item_t;
  item_t sb[$];
  logic [W-1:0] last_out = '0;

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input bit m);
    logic [W-1:0] w;
    logic [7:0]   s;
    bit           p;
    w = d;
    if (m) w[255:252] = 4'hF;
    s = 8'd0;
    p = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (w[i]) begin
        p = ~p;
        s = s ^ 8'(i);
      end
    end
    if (s < 8'd252) begin
      w[s] = ~w[s];
      p    = ~p;
    end else begin
      w[s - 8'd4] = ~w[s - 8'd4];
      w[4]        = ~w[4];
    end
    w[0] = w[0] ^ p;
    return w;
  endfunction

  function automatic logic [7:0] idx_xor(input logic [W-1:0] w);
    logic [7:0] s;
    s = 8'd0;
    for (int i = 0; i < W; i++) if (w[i]) s = s ^ 8'(i);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: caller sits just after a rising edge
  task automatic send(input logic [W-1:0] d, input bit m, input bit keep);
    item_t it;
    start_i   = 1'b1;
    data_i    = d;
    minimal_i = m;
    it.exp = model(d, m);
    it.top = m ? 4'hF : d[255:252];
    it.due = cyc + 2;
    sb.push_back(it);
    @(posedge clk); #1;
    if (!keep) start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected done", code_o, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.due == cyc, "R2 done timing", W'(cyc), W'(it.due));
          check(code_o == it.exp, "R8 code word", code_o, it.exp);
          check(idx_xor(code_o) == 8'd0, "R4 index xor", W'(idx_xor(code_o)), '0);
          check(!(^code_o), "R5 even weight", W'(^code_o), '0);
          check(code_o[255:252] == it.top, "R6/R7 top bits R6 R7",
                W'(code_o[255:252]), W'(it.top));
          last_out = code_o;
        end
      end else begin
        check(code_o == last_out, "R3 hold", code_o, last_out);
        if (sb.size() != 0 && sb[0].due <= cyc) begin
          item_t it;
          it = sb.pop_front();
          check(1'b0, "R2 missing done", W'(cyc), W'(it.due));
        end
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc > 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] hand;
    rst_n = 1'b0; start_i = 1'b0; minimal_i = 1'b0; data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(code_o == '0, "R1 reset code", code_o, '0);
    check(done_o == 1'b0, "R1 reset done", W'(done_o), '0);
    #1 rst_n = 1'b1;
    idle(4);
    mon_on = 1;

    // R9: already valid words
    send('0, 1'b0, 1'b0); idle(3);
    check(last_out == '0, "R9 zeros", last_out, '0);
    send({W{1'b1}}, 1'b0, 1'b0); idle(3);
    check(last_out == {W{1'b1}}, "R9 ones", last_out, {W{1'b1}});
    send('0, 1'b1, 1'b0); idle(3);
    hand = '0; hand[255:252] = 4'hF;
    check(last_out == hand, "R9 R6 minimal zeros", last_out, hand);

    // R8: syndrome in reserved range (single bit 253)
    v = '0; v[253] = 1'b1;
    send(v, 1'b0, 1'b0); idle(3);
    hand = '0; hand[253] = 1'b1; hand[249] = 1'b1; hand[4] = 1'b1; hand[0] = 1'b1;
    check(last_out == hand, "R8 pair fix", last_out, hand);
    // R8: syndrome below limit (single bit 7) cancels to zero
    v = '0; v[7] = 1'b1;
    send(v, 1'b0, 1'b0); idle(3);
    check(last_out == '0, "R8 single fix", last_out, '0);

    // R3: long idle hold is checked by monitor
    idle(10);

    // Random, both modes
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
      send(v, n[0], 1'b0);
      idle(n % 3);
    end
    idle(4);

    // R10: back-to-back starts
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
      send(v, n[1], 1'b1);
    end
    start_i = 1'b0;
    idle(6);
    check(sb.size() == 0, "R10 all results seen", W'(sb.size()), '0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule